// File: doc/BRIEF.md
# Management Alert Frame Transmit Buffer

This block keeps one management or alert Ethernet frame and plays it out to a MAC. A host writes the frame a byte at a time over a serial management bus. Every data byte of a block write whose command code matches the transmit-data code goes into a 128-byte store. The byte lands at the location held by a write pointer, and the pointer then advances. The host may move the pointer to any location to patch a single byte. It also writes a length register that says how many stored bytes form the frame.

A start strobe sends the frame. The bytes go out from location 0, which holds the first destination-address byte, up to location length-1, on a valid/ready byte stream. A computed 32-bit frame check sequence follows them. The block never pads a short frame. A length below 60 gives a runt frame on the wire, exactly as loaded.

Top module: `mgmt_alert_txbuf`

## Requirements
- R1: A data byte is stored only when `smb_wr_valid` is high and `smb_cmd` equals 36 (decimal). A byte that comes with any other command code changes neither the store nor the write pointer.
- R2: The data interface has no byte-count field. A block of any length, including more than 32 bytes, is stored completely.
- R3: The write pointer is 0 after reset and advances by one after every stored byte. It wraps from 127 to 0.
- R4: When `ptr_load` is high, the write pointer takes `ptr_value` in the next cycle. The next stored byte overwrites that location and leaves the others unchanged.
- R5: The length register is 0 after reset and takes `len_value` when `len_load` is high. An accepted start sends the stored bytes from location 0 to location length-1 in order, at one byte per valid/ready handshake.
- R6: After the stored bytes come exactly four FCS bytes. The FCS is the complemented CRC-32 (reflected polynomial 0xEDB88320, initial value all ones) over the sent bytes, least significant byte first. `tx_last` is high on the final FCS byte only.
- R7: No padding is added. A frame of length L has exactly L+4 bytes, also when L is below 60.
- R8: `tx_busy` rises in the cycle after an accepted start and falls in the cycle after the handshake of the last byte. A start while busy is ignored.
- R9: A start while the length register holds 0 or a value above 128 is ignored: `tx_busy` and `tx_valid` stay low.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smb_cmd | input | 8 | Command code of the current block write |
| smb_wr_valid | input | 1 | A data byte of the block write is present |
| smb_wr_data | input | 8 | Data byte |
| ptr_load | input | 1 | Load the write pointer |
| ptr_value | input | 7 | New write pointer value |
| len_load | input | 1 | Load the length register |
| len_value | input | 8 | New frame length in bytes |
| tx_start | input | 1 | Start strobe for transmission |
| tx_ready | input | 1 | MAC accepts the current byte |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final FCS byte |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The main readout is tried with lengths of 1, 5, 17, 60, 64 and 128, each with its own fill pattern and its own `tx_ready` pattern. Full ready tells apart wrong byte order and wrong CRC coverage. Sparse and alternating ready patterns show whether a byte is skipped or repeated while the MAC stalls. The 1-byte and 5-byte frames show whether the block pads short frames, and the 128-byte frame tests the index at the far end of the store. Directed writes with a foreign command code, a repositioned pointer and a pointer wrap show whether the store is written at the right places. Starts with lengths 0 and 129, and a start while busy, show whether an unwanted transmission can begin.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BODY = 2'd1,
      ST_FCS  = 2'd2
   } mtx_state_e;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

   function automatic logic [31:0] crc_byte_step(input logic [31:0] c_in,
                                                 input logic [7:0]  b);
      logic [31:0] c;
      c = c_in;
      for (int k = 0; k < 8; k++) begin
         if (c[0] ^ b[k]) c = (c >> 1) ^ CRC_POLY_REFL;
         else             c = c >> 1;
      end
      return c;
   endfunction
endpackage

// File: rtl/mtx_store.sv
module mtx_store #(
   parameter int DEPTH = 128,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          ptr_load,
   input  logic [PW-1:0] ptr_value,
   input  logic [PW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [PW-1:0] wr_ptr
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] ptr_inc;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2_wrap
         assign ptr_inc = wr_ptr + PW'(1);
      end else begin : g_cmp_wrap
         assign ptr_inc = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        wr_ptr <= '0;
      else if (ptr_load) wr_ptr <= ptr_value;
      else if (wr_en)    wr_ptr <= ptr_inc;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mtx_crc.sv
module mtx_crc
   import mtx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        step_en,
   input  logic [7:0]  step_byte,
   output logic [31:0] crc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= CRC_SEED;
      else if (init)    crc_q <= CRC_SEED;
      else if (step_en) crc_q <= crc_byte_step(crc_q, step_byte);
   end
endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
   import mtx_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len,
   input  logic          tx_ready,
   output logic [PW-1:0] rd_addr,
   output logic          sel_fcs,
   output logic [1:0]    fcs_idx,
   output logic          tx_valid,
   output logic          tx_last,
   output logic          busy,
   output logic          crc_init,
   output logic          crc_step
);
   mtx_state_e    state;
   logic [LW-1:0] idx;
   logic [LW-1:0] len_q;
   logic          len_ok;
   logic          hand;

   assign len_ok   = (len != '0) && (len <= LW'(DEPTH));
   assign crc_init = (state == ST_IDLE) && start && len_ok;
   assign tx_valid = (state != ST_IDLE);
   assign hand     = tx_valid && tx_ready;
   assign crc_step = (state == ST_BODY) && hand;
   assign sel_fcs  = (state == ST_FCS);
   assign tx_last  = sel_fcs && (fcs_idx == 2'd3);
   assign busy     = tx_valid;
   assign rd_addr  = idx[PW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         len_q   <= '0;
         fcs_idx <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (crc_init) begin
               state <= ST_BODY;
               idx   <= '0;
               len_q <= len;
            end
            ST_BODY: if (hand) begin
               if (idx == len_q - LW'(1)) begin
                  state   <= ST_FCS;
                  fcs_idx <= '0;
               end else begin
                  idx <= idx + LW'(1);
               end
            end
            ST_FCS: if (hand) begin
               if (fcs_idx == 2'd3) state <= ST_IDLE;
               else                 fcs_idx <= fcs_idx + 2'd1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mgmt_alert_txbuf.sv
module mgmt_alert_txbuf #(
   parameter int DEPTH    = 128,
   parameter int CMD_W    = 8,
   parameter int CMD_CODE = 36,
   localparam int PW      = $clog2(DEPTH),
   localparam int LW      = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] smb_cmd,
   input  logic             smb_wr_valid,
   input  logic [7:0]       smb_wr_data,
   input  logic             ptr_load,
   input  logic [PW-1:0]    ptr_value,
   input  logic             len_load,
   input  logic [LW-1:0]    len_value,
   input  logic             tx_start,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic             tx_busy
);
   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("mgmt_alert_txbuf: DEPTH must be at least 4");
      end
      if (CMD_CODE >= (1 << CMD_W)) begin : g_bad_code
         $error("mgmt_alert_txbuf: CMD_CODE does not fit in CMD_W bits");
      end
   endgenerate

   logic          wr_en;
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_addr;
   logic [7:0]    rd_data;
   logic [LW-1:0] len_q;
   logic          sel_fcs;
   logic [1:0]    fcs_idx;
   logic          crc_init;
   logic          crc_step;
   logic [31:0]   crc_q;
   logic [31:0]   fcs_word;

   assign wr_en = smb_wr_valid && (smb_cmd == CMD_W'(CMD_CODE));

   always_ff @(posedge clk) begin
      if (!rst_n)        len_q <= '0;
      else if (len_load) len_q <= len_value;
   end

   mtx_store #(.DEPTH(DEPTH), .DW(8)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (smb_wr_data),
      .ptr_load  (ptr_load),
      .ptr_value (ptr_value),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .wr_ptr    (wr_ptr)
   );

   mtx_seq #(.DEPTH(DEPTH)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tx_start),
      .len      (len_q),
      .tx_ready (tx_ready),
      .rd_addr  (rd_addr),
      .sel_fcs  (sel_fcs),
      .fcs_idx  (fcs_idx),
      .tx_valid (tx_valid),
      .tx_last  (tx_last),
      .busy     (tx_busy),
      .crc_init (crc_init),
      .crc_step (crc_step)
   );

   mtx_crc u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (crc_init),
      .step_en   (crc_step),
      .step_byte (rd_data),
      .crc_q     (crc_q)
   );

   assign fcs_word = ~crc_q;
   assign tx_data  = sel_fcs ? fcs_word[{fcs_idx, 3'b000} +: 8] : rd_data;
endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
   parameter int DEPTH    = 128,
   parameter int CMD_W    = 8,
   parameter int CMD_CODE = 36,
   localparam int PW      = $clog2(DEPTH),
   localparam int LW      = PW + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CMD_W-1:0] smb_cmd,
   input logic             smb_wr_valid,
   input logic             ptr_load,
   input logic [PW-1:0]    ptr_value,
   input logic [PW-1:0]    wr_ptr,
   input logic [LW-1:0]    len_q,
   input logic             tx_start,
   input logic             tx_ready,
   input logic             tx_valid,
   input logic [7:0]       tx_data,
   input logic             tx_last,
   input logic             tx_busy
);
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (smb_wr_valid && smb_cmd == CMD_W'(CMD_CODE) && !ptr_load)
         |=> (wr_ptr == PW'($past(wr_ptr) + PW'(1))));

   p_foreign_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smb_cmd != CMD_W'(CMD_CODE) && !ptr_load) |=> $stable(wr_ptr));

   p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load |=> (wr_ptr == $past(ptr_value)));

   p_start_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && tx_start && len_q != '0 && len_q <= LW'(DEPTH))
         |=> (tx_busy && tx_valid));

   p_last_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> (tx_valid && tx_busy));

   p_end_of_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !tx_busy);

   p_bad_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && tx_start && (len_q == '0 || len_q > LW'(DEPTH)))
         |=> (!tx_busy && !tx_valid));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready)
         |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

bind mgmt_alert_txbuf mtx_checker #(
   .DEPTH(DEPTH), .CMD_W(CMD_W), .CMD_CODE(CMD_CODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .smb_cmd      (smb_cmd),
   .smb_wr_valid (smb_wr_valid),
   .ptr_load     (ptr_load),
   .ptr_value    (ptr_value),
   .wr_ptr       (wr_ptr),
   .len_q        (len_q),
   .tx_start     (tx_start),
   .tx_ready     (tx_ready),
   .tx_valid     (tx_valid),
   .tx_data      (tx_data),
   .tx_last      (tx_last),
   .tx_busy      (tx_busy)
);

// File: tb/mgmt_alert_txbuf_bench.sv
module mgmt_alert_txbuf_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] smb_cmd = '0;
   logic       smb_wr_valid = 1'b0;
   logic [7:0] smb_wr_data = '0;
   logic       ptr_load = 1'b0;
   logic [6:0] ptr_value = '0;
   logic       len_load = 1'b0;
   logic [7:0] len_value = '0;
   logic       tx_start = 1'b0;
   logic       tx_ready = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_last;
   logic       tx_busy;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   logic [7:0] model [128];
   logic [7:0] got [160];
   int         got_n;
   int         last_cnt;
   int         last_pos;

   // vector: {length, fill seed, fill step, ready pattern}
   localparam logic [31:0] VEC [6] = '{
      {8'd60,  8'h11, 8'd3,  8'hFF},
      {8'd1,   8'hA5, 8'd1,  8'hFF},
      {8'd128, 8'h00, 8'd1,  8'hB7},
      {8'd17,  8'h3C, 8'd7,  8'h5A},
      {8'd64,  8'hF0, 8'd13, 8'h81},
      {8'd5,   8'h77, 8'd29, 8'hFF}
   };

   mgmt_alert_txbuf u_mgmt_alert_txbuf (
      .clk(clk), .rst_n(rst_n), .smb_cmd(smb_cmd), .smb_wr_valid(smb_wr_valid),
      .smb_wr_data(smb_wr_data), .ptr_load(ptr_load), .ptr_value(ptr_value),
      .len_load(len_load), .len_value(len_value), .tx_start(tx_start),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_busy(tx_busy)
   );

   always #2 clk = ~clk;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < 8; k++) begin
            if (c[0] ^ model[i][k]) c = (c >> 1) ^ 32'hEDB88320;
            else                    c = c >> 1;
         end
      end
      return ~c;
   endfunction

   task automatic wr(input logic [7:0] code, input logic [7:0] d);
      @(negedge clk);
      smb_cmd = code; smb_wr_valid = 1'b1; smb_wr_data = d;
      @(negedge clk);
      smb_wr_valid = 1'b0;
   endtask

   task automatic set_ptr(input logic [6:0] p);
      @(negedge clk); ptr_load = 1'b1; ptr_value = p;
      @(negedge clk); ptr_load = 1'b0;
   endtask

   task automatic set_len(input logic [7:0] l);
      @(negedge clk); len_load = 1'b1; len_value = l;
      @(negedge clk); len_load = 1'b0;
   endtask

   // start then gather bytes; poke: iteration at which start is pulsed again
   task automatic send(input logic [7:0] pat, input int poke);
      got_n = 0; last_cnt = 0; last_pos = -1;
      @(negedge clk); tx_start = 1'b1;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         tx_start = (k == poke);
         tx_ready = pat[k % 8];
         #1;
         if (tx_valid && tx_ready) begin
            if (got_n < 160) got[got_n] = tx_data;
            if (tx_last) begin last_cnt++; last_pos = got_n; end
            got_n++;
            if (tx_last) break;
         end
      end
      @(negedge clk); tx_ready = 1'b0; tx_start = 1'b0;
   endtask

   task automatic check_frame(input int len, input string tag);
      logic [31:0] f;
      int bad;
      f = ref_crc(len);
      bad = 0;
      chk(got_n == len + 4, {tag, " R7 frame size"}, got_n, len + 4);
      for (int i = 0; i < len && i < got_n; i++)
         if (got[i] !== model[i]) begin
            bad++;
            chk(1'b0, {tag, " R5 data byte"}, int'(got[i]), int'(model[i]));
         end
      if (bad == 0) chk(1'b1, {tag, " R5 data"}, 0, 0);
      if (got_n == len + 4)
         chk({got[len+3], got[len+2], got[len+1], got[len]} === f,
             {tag, " R6 fcs"}, int'({got[len+3], got[len+2], got[len+1], got[len]}), int'(f));
      chk(last_cnt == 1 && last_pos == len + 3, {tag, " R6 last position"}, last_pos, len + 3);
   endtask

   initial begin
      logic [7:0] l, s, st, p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!tx_busy && !tx_valid && !tx_last, "R8 reset idle", {tx_busy, tx_valid, tx_last}, 0);

      // R3: pointer starts at 0; R5: length 0 after reset, start ignored (R9)
      @(negedge clk); tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0; #1;
      chk(!tx_busy && !tx_valid, "R9 reset length 0 start ignored", tx_busy, 0);
      wr(8'd36, 8'hC3); model[0] = 8'hC3;
      set_len(8'd1);
      send(8'hFF, -1);
      check_frame(1, "R3 reset pointer");

      // R1: foreign command code ignored
      set_ptr(7'd0);
      wr(8'd36, 8'h12); model[0] = 8'h12;
      wr(8'd35, 8'h99);
      wr(8'd37, 8'h98);
      wr(8'd36, 8'h34); model[1] = 8'h34;
      set_len(8'd2);
      send(8'hFF, -1);
      check_frame(2, "R1 foreign code");

      // table walk: R2 long blocks, R5/R6/R7/R10 under ready patterns
      foreach (VEC[v]) begin
         {l, s, st, p} = VEC[v];
         set_ptr(7'd0);
         for (int i = 0; i < int'(l); i++) begin
            model[i] = s + 8'(i) * st;
            wr(8'd36, model[i]);
         end
         set_len(l);
         send(p, -1);
         check_frame(int'(l), $sformatf("R2 R10 vec%0d", v));
      end

      // R4: reposition and overwrite one byte
      set_ptr(7'd3);
      wr(8'd36, 8'hEE); model[3] = 8'hEE;
      set_len(8'd10);
      send(8'hFF, -1);
      check_frame(10, "R4 overwrite");

      // R3: wrap from 127 to 0
      set_ptr(7'd126);
      wr(8'd36, 8'h61); model[126] = 8'h61;
      wr(8'd36, 8'h62); model[127] = 8'h62;
      wr(8'd36, 8'h63); model[0] = 8'h63;
      wr(8'd36, 8'h64); model[1] = 8'h64;
      set_len(8'd128);
      send(8'hFF, -1);
      check_frame(128, "R3 wrap");

      // R9: length above 128
      set_len(8'd129);
      @(negedge clk); tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0; #1;
      chk(!tx_busy && !tx_valid, "R9 length 129 start ignored", tx_busy, 0);
      set_len(8'd0);
      @(negedge clk); tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0; #1;
      chk(!tx_busy && !tx_valid, "R9 length 0 start ignored", tx_busy, 0);

      // R8: start while busy ignored
      set_len(8'd8);
      send(8'hFF, 4);
      check_frame(8, "R8 start while busy");
      @(negedge clk); #1;
      chk(!tx_busy, "R8 idle after last", tx_busy, 0);
      repeat (4) @(negedge clk);
      #1;
      chk(!tx_busy && !tx_valid, "R8 no second frame", tx_valid, 0);

      summary();
   end
endmodule